// File: doc/BRIEF.md
# Reference Edge Timestamper

This block stamps rising edges of an external reference signal with the value of a free-running timer. The timer advances once every `P+1` clock cycles, where `P` is a programmable prescale value. It counts from zero up to a programmable top value and then returns to zero. The reference pin is asynchronous. It passes through a synchroniser, and the block then looks for a low-to-high transition. Each transition it finds copies the timer count into a capture register and marks that capture as unread.

A consumer reads the capture with a one-cycle read strobe. If a second edge arrives before the first capture has been read, the older timestamp is lost. The block then raises a sticky over-capture fault, so the loss is always visible and the sampling parameters can be corrected. The fault holds until reset or until an explicit clear pulse.

Top module: `edge_stamp_top`

## Requirements
- R1: After reset the captured value is 0 and the pending and over-capture flags are both 0. The timer starts from count 0 with its prescale phase at 0.
- R2: With prescale value P on `prescale_i`, the timer count increases by one on every (P+1)-th rising clock edge after reset is released, so after n such edges the count is floor(n/(P+1)) modulo (W+1).
- R3: The count never goes above the top value W on `wrap_i`. On the tick that finds the count at W or above, the count returns to 0.
- R4: A 0-to-1 change on `pin_i` passes through two synchroniser flops. The edge is detected one cycle after the second flop goes high, and `stamp_o` takes the timer count of that detection cycle. The pin is set up before clock edge n+1, and the stamp is visible after edge n+3 with the count that held after edge n+2.
- R5: Falling edges and steady levels on `pin_i` capture nothing: `stamp_o` and `pending_o` keep their values.
- R6: A capture sets `pending_o`. A read strobe `rd_i` in a cycle with no new edge clears `pending_o` at the next clock edge.
- R7: An edge detected while `pending_o` is 1 and `rd_i` is 0 sets `overcap_o` and still loads the new count into `stamp_o`.
- R8: An edge detected in the same cycle as `rd_i` loads the new count and leaves `pending_o` at 1. It does not set `overcap_o`.
- R9: `overcap_o` stays at 1 until reset or a pulse on `overcap_clr_i`. When a clear and a new over-capture happen in the same cycle, the flag stays set.
- R10: `rd_i` while nothing is pending has no effect: `stamp_o`, `pending_o` and `overcap_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous reference input |
| rd_i | input | 1 | Read strobe for the capture |
| overcap_clr_i | input | 1 | Clears the sticky over-capture flag |
| prescale_i | input | 32 | Tick prescale value P (one tick per P+1 cycles) |
| wrap_i | input | 32 | Top count W, after which the timer returns to 0 |
| stamp_o | output | 32 | Last captured timer value |
| pending_o | output | 1 | A capture has not yet been read |
| overcap_o | output | 1 | Sticky fault: an unread capture was overwritten |

## Verification
The timer is checked only through captured stamps, under several prescale and top-value pairs. These include P=0 and small top values that force many wraps, which separates a wrong tick rate from a wrong wrap point. Random gaps between edges move the capture phase across prescale and wrap boundaries, and they catch an off-by-one in the synchroniser latency. Directed cases cover:
- back-to-back edges without a read
- an edge that collides with a read
- an edge that collides with a clear
- a read while nothing is pending
- falling edges only

Each of these separates the over-capture rule from the pending rule.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;

    parameter int unsigned STAMP_W = 32;

    typedef logic [STAMP_W-1:0] stamp_t;

    typedef struct packed {
        stamp_t presc;
        stamp_t count;
    } timer_state_t;

    typedef struct packed {
        stamp_t stamp;
        logic   pending;
        logic   overcap;
    } capture_state_t;

endpackage

// File: rtl/stamp_edge_sync.sv
module stamp_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] sync_d, sync_q;
    logic              prev_d, prev_q;

    always_comb begin
        sync_d[0] = pin_i;
        prev_d    = sync_q[LAST];
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_chain
        always_comb sync_d[g] = sync_q[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            prev_q <= prev_d;
        end
    end

    assign rise_o = sync_q[LAST] & ~prev_q;

    // A single level change can produce only one detection pulse.
    assert_edge_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);

endmodule

// File: rtl/stamp_timebase.sv
module stamp_timebase
    import edge_stamp_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  stamp_t prescale_i,
    input  stamp_t wrap_i,
    output stamp_t count_o
);
    timer_state_t st_d, st_q;
    logic         tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.presc >= prescale_i);
        if (tick) begin
            st_d.presc = '0;
            if (st_q.count >= wrap_i) st_d.count = '0;
            else                      st_d.count = st_q.count + 1'b1;
        end else begin
            st_d.presc = st_q.presc + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign count_o = st_q.count;

    assert_count_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tick |=> $stable(st_q.count));
    assert_wrap_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick && st_q.count >= wrap_i) |=> (st_q.count == '0));

endmodule

// File: rtl/stamp_capture.sv
module stamp_capture
    import edge_stamp_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   rise_i,
    input  logic   rd_i,
    input  logic   clr_i,
    input  stamp_t count_i,
    output stamp_t stamp_o,
    output logic   pending_o,
    output logic   overcap_o
);
    capture_state_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (clr_i)            cs_d.overcap = 1'b0;
        if (rd_i)             cs_d.pending = 1'b0;
        if (rise_i) begin
            cs_d.stamp   = count_i;
            cs_d.pending = 1'b1;
            if (cs_q.pending && !rd_i) cs_d.overcap = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cs_q <= '0;
        else         cs_q <= cs_d;
    end

    assign stamp_o   = cs_q.stamp;
    assign pending_o = cs_q.pending;
    assign overcap_o = cs_q.overcap;

    assert_capture_sets_pending_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_i |=> cs_q.pending);
    assert_read_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !rise_i) |=> !cs_q.pending);
    assert_overcap_raise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i && cs_q.pending && !rd_i) |=> cs_q.overcap);
    assert_collision_clean_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i && rd_i && !cs_q.overcap) |=> !cs_q.overcap);
    assert_overcap_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_q.overcap && !clr_i) |=> cs_q.overcap);
    assert_stamp_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rise_i |=> $stable(cs_q.stamp));

endmodule

// File: rtl/edge_stamp_top.sv
module edge_stamp_top
    import edge_stamp_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               pin_i,
    input  logic               rd_i,
    input  logic               overcap_clr_i,
    input  logic [STAMP_W-1:0] prescale_i,
    input  logic [STAMP_W-1:0] wrap_i,
    output logic [STAMP_W-1:0] stamp_o,
    output logic               pending_o,
    output logic               overcap_o
);
    logic   rise;
    stamp_t count;

    stamp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (pin_i),
        .rise_o (rise)
    );

    stamp_timebase u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .prescale_i (prescale_i),
        .wrap_i     (wrap_i),
        .count_o    (count)
    );

    stamp_capture u_cap (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (rise),
        .rd_i      (rd_i),
        .clr_i     (overcap_clr_i),
        .count_i   (count),
        .stamp_o   (stamp_o),
        .pending_o (pending_o),
        .overcap_o (overcap_o)
    );

    // The stamp is always a count the timer can reach.
    assert_stamp_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $stable(wrap_i) |-> (stamp_o <= wrap_i || !pending_o));

endmodule

// File: tb/edge_stamp_top_bench.sv
module edge_stamp_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic        rd = 1'b0;
    logic        clr = 1'b0;
    logic [31:0] presc = 32'd0;
    logic [31:0] wrap = 32'd9;
    logic [31:0] stamp;
    logic        pending;
    logic        overcap;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    edge_stamp_top u_edge_stamp_top (
        .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .rd_i(rd),
        .overcap_clr_i(clr), .prescale_i(presc), .wrap_i(wrap),
        .stamp_o(stamp), .pending_o(pending), .overcap_o(overcap)
    );

    function automatic logic [31:0] exp_count(int n);
        longint ticks;
        ticks = longint'(n) / (longint'(presc) + 1);
        return 32'(ticks % (longint'(wrap) + 1));
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(logic [31:0] p, logic [31:0] w);
        @(negedge clk);
        rst_n = 1'b0; pin = 1'b0; rd = 1'b0; clr = 1'b0;
        presc = p; wrap = w;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Raise the pin at a negedge; return expected stamp after capture.
    task automatic edge_capture(output logic [31:0] exp_v);
        int n0;
        pin = 1'b1; n0 = cyc;
        repeat (3) @(negedge clk);
        exp_v = exp_count(n0 + 2);
    endtask

    task automatic drop_pin(int gap);
        pin = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic do_read();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] e;
        logic [31:0] held;
        int n0;

        do_reset(32'd0, 32'd9);
        check("R1 stamp", stamp, 32'd0);
        check("R1 pending", {31'd0, pending}, 32'd0);
        check("R1 overcap", {31'd0, overcap}, 32'd0);

        // R4 basic capture, R2 with P=0
        repeat (5) @(negedge clk);
        edge_capture(e);
        check("R4 stamp", stamp, e);
        check("R6 pending set", {31'd0, pending}, 32'd1);
        drop_pin(3);
        do_read();
        check("R6 read clears", {31'd0, pending}, 32'd0);

        // R10 read with nothing pending
        held = stamp;
        do_read();
        check("R10 stamp", stamp, held);
        check("R10 pending", {31'd0, pending}, 32'd0);
        check("R10 overcap", {31'd0, overcap}, 32'd0);

        // R5 falling edge and steady high capture nothing
        pin = 1'b1;
        repeat (3) @(negedge clk);
        do_read();
        held = stamp;
        repeat (6) @(negedge clk);
        pin = 1'b0;
        repeat (6) @(negedge clk);
        check("R5 stamp", stamp, held);
        check("R5 pending", {31'd0, pending}, 32'd0);

        // R7 over-capture: two edges without read
        edge_capture(e);
        drop_pin(3);
        edge_capture(e);
        check("R7 overcap", {31'd0, overcap}, 32'd1);
        check("R7 new stamp", stamp, e);
        drop_pin(3);
        // R9 sticky across read
        do_read();
        repeat (4) @(negedge clk);
        check("R9 sticky", {31'd0, overcap}, 32'd1);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R9 clear", {31'd0, overcap}, 32'd0);

        // R8 edge coincides with read
        edge_capture(e);
        drop_pin(3);
        pin = 1'b1; n0 = cyc;
        repeat (2) @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        check("R8 stamp", stamp, exp_count(n0 + 2));
        check("R8 pending", {31'd0, pending}, 32'd1);
        check("R8 overcap", {31'd0, overcap}, 32'd0);
        drop_pin(3);

        // R9 clear collides with a new over-capture: set wins
        pin = 1'b1;
        repeat (2) @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R9 set beats clear", {31'd0, overcap}, 32'd1);
        drop_pin(3);

        // R2/R3/R4 random configurations, fixed seed
        begin
            int seed_dummy;
            seed_dummy = $urandom(32'h5eed1234);
        end
        for (int cfg = 0; cfg < 6; cfg++) begin
            logic [31:0] p, w;
            p = (cfg == 0) ? 32'd0 : ($urandom % 6);
            w = (cfg == 1) ? 32'd1 : (32'd2 + ($urandom % 30));
            do_reset(p, w);
            for (int k = 0; k < 12; k++) begin
                int gap;
                gap = 1 + ($urandom % 40);
                repeat (gap) @(negedge clk);
                edge_capture(e);
                check("R2 R3 R4 random stamp", stamp, e);
                drop_pin(3);
                do_read();
            end
            check("R7 no overcap when read", {31'd0, overcap}, 32'd0);
        end

        // R3 long run with large prescale and wrap near count
        do_reset(32'd2, 32'd3);
        repeat (100) @(negedge clk);
        edge_capture(e);
        check("R3 wrap stamp", stamp, e);
        drop_pin(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule